// File: doc/BRIEF.md
# Four-Phase Sequential / Parallel Handshake Activator

This control block sits between one parent channel and two child channels. Every channel is a request/acknowledge wire pair that uses four-phase, return-to-zero signalling. In each transfer the request rises and then the acknowledge rises, which is the active phase. The request then falls and the acknowledge falls, which returns the channel to zero. The parent channel is passive: its environment raises the request. The two child channels are active: the block raises their requests.

A build-time parameter selects how the children are run. In sequential mode, one parent activation drives a full handshake on the first child. The handshake on the second child starts only after the first has returned to zero. In parallel mode, both children are activated in the same cycle and the block waits for both. In either mode the parent is acknowledged only after every child channel is back at zero. The parent acknowledge stays high until the parent request is withdrawn. The block is a clocked state machine, and all of its outputs come directly from registers.

Top module: `hs_seq_par`

## Requirements
- R1: While rst_ni is low, p_ack_o, a1_req_o and a2_req_o are 0, even when p_req_i is high.
- R2: On each child channel, a request stays high until its acknowledge is seen high, and it then falls. A new request is never raised while that channel's acknowledge is still high.
- R3: With PAR_MODE = 0, the rise of a2_req_o comes strictly after the cycle in which a1_ack_i returned to 0.
- R4: With PAR_MODE = 1, a1_req_o and a2_req_o rise in the same clock cycle.
- R5: p_ack_o rises only when a1_req_o, a1_ack_i, a2_req_o and a2_ack_i are all 0, and strictly after the later of the two child acknowledge falls.
- R6: Once p_ack_o is high, it stays high for as long as p_req_i is high. It falls only after p_req_i has gone to 0.
- R7: While p_req_i and p_ack_o are both low, neither child request is high.
- R8: Each parent handshake produces exactly one request rise on each child channel. A new parent request after return-to-zero starts a fresh round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_req_i | input | 1 | Parent channel request (passive side) |
| p_ack_o | output | 1 | Parent channel acknowledge |
| a1_req_o | output | 1 | First child channel request |
| a1_ack_i | input | 1 | First child channel acknowledge |
| a2_req_o | output | 1 | Second child channel request |
| a2_ack_i | input | 1 | Second child channel acknowledge |

## Verification
Both mode variants are driven from the same parent request and the same child response delays. The rising and falling delays of each child responder are set independently. Delay vectors in which the first child is slower than the second, or faster, separate a correct join from one that waits on a single child in parallel mode. The same vectors separate a correct sequence from an early start of the second child in sequential mode. Zero-delay responses stress back-to-back edges. Long parent hold times and randomised delays confirm that the acknowledge is held, that the children stay quiet between rounds, and that each round yields exactly one handshake per child.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned HS_NUM_CH = 2;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_REQ,
    CH_RTZ,
    CH_DONE
  } ch_state_e;

  typedef enum logic [1:0] {
    PA_IDLE,
    PA_FIRST,
    PA_SECOND,
    PA_ACK
  } pa_state_e;
endpackage

// File: rtl/hs_child_ch.sv
module hs_child_ch
  import hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);

  ch_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_IDLE, CH_DONE: if (go_i)   state_d = CH_REQ;
      CH_REQ:           if (ack_i)  state_d = CH_RTZ;
      CH_RTZ:           if (!ack_i) state_d = CH_DONE;
      default:                      state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CH_IDLE;
    else         state_q <= state_d;
  end

  assign req_o  = (state_q == CH_REQ);
  assign done_o = (state_q == CH_DONE);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o);  // R2
  AST_NO_REQ_ACK_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && ack_i |=> !req_o);  // R2
  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !req_o && !ack_i);  // R5

endmodule

// File: rtl/hs_parent_fsm.sv
module hs_parent_fsm
  import hs_pkg::*;
#(
  parameter bit PAR_MODE = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 p_req_i,
  input  logic [HS_NUM_CH-1:0] done_i,
  output logic [HS_NUM_CH-1:0] go_o,
  output logic                 p_ack_o
);

  pa_state_e state_q, state_d;
  logic [HS_NUM_CH-1:0] first_go;
  logic                 first_join;

  generate
    if (PAR_MODE) begin : g_par
      assign first_go   = '1;
      assign first_join = &done_i;
    end else begin : g_seq
      assign first_go   = HS_NUM_CH'(1);
      assign first_join = done_i[0];
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    go_o    = '0;
    unique case (state_q)
      PA_IDLE: if (p_req_i) begin
        state_d = PA_FIRST;
        go_o    = first_go;
      end
      PA_FIRST: if (first_join) begin
        if (PAR_MODE) begin
          state_d = PA_ACK;
        end else begin
          state_d = PA_SECOND;
          go_o    = HS_NUM_CH'(2);
        end
      end
      PA_SECOND: if (done_i[1]) state_d = PA_ACK;
      PA_ACK:    if (!p_req_i)  state_d = PA_IDLE;
      default:                  state_d = PA_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PA_IDLE;
    else         state_q <= state_d;
  end

  assign p_ack_o = (state_q == PA_ACK);

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_ack_o && p_req_i |=> p_ack_o);  // R6
  AST_GO_ONEHOT_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !PAR_MODE |-> $onehot0(go_o));  // R3

endmodule

// File: rtl/hs_seq_par.sv
module hs_seq_par
  import hs_pkg::*;
#(
  parameter bit PAR_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic p_req_i,
  output logic p_ack_o,
  output logic a1_req_o,
  input  logic a1_ack_i,
  output logic a2_req_o,
  input  logic a2_ack_i
);

  logic [HS_NUM_CH-1:0] ack_v, req_v, go_v, done_v;

  assign ack_v = {a2_ack_i, a1_ack_i};

  hs_parent_fsm #(.PAR_MODE(PAR_MODE)) i_parent (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .p_req_i (p_req_i),
    .done_i  (done_v),
    .go_o    (go_v),
    .p_ack_o (p_ack_o)
  );

  for (genvar c = 0; c < HS_NUM_CH; c++) begin : g_ch
    hs_child_ch i_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (go_v[c]),
      .ack_i  (ack_v[c]),
      .req_o  (req_v[c]),
      .done_o (done_v[c])
    );
  end

  assign a1_req_o = req_v[0];
  assign a2_req_o = req_v[1];

  generate
    if (PAR_MODE) begin : g_ast_par
      AST_PAR_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(a1_req_o) |-> $rose(a2_req_o));  // R4
    end else begin : g_ast_seq
      AST_SEQ_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(a2_req_o) |-> !a1_req_o && !a1_ack_i);  // R3
    end
  endgenerate

  AST_ACK_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p_ack_o) |-> !a1_req_o && !a1_ack_i && !a2_req_o && !a2_ack_i);  // R5
  AST_ACK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(p_ack_o) |-> !p_req_i);  // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_req_i && !p_ack_o |-> !a1_req_o && !a2_req_o);  // R7
  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> !p_ack_o && !a1_req_o && !a2_req_o);  // R1

endmodule

// File: tb/test_hs_seq_par.sv
module test_responder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [3:0] dly_rise,
  input  logic [3:0] dly_fall,
  input  int         cyc,
  output logic       ack,
  output int         rise_cyc,
  output int         fall_cyc,
  output int         n_rise,
  output int         n_viol
);
  logic prev_req;

  initial begin
    ack = 1'b0;
    fall_cyc = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ack = 1'b0;
      end else if (req && !ack) begin
        repeat (dly_rise) @(posedge clk);
        #1 ack = 1'b1;
      end else if (!req && ack) begin
        repeat (dly_fall) @(posedge clk);
        #1 ack = 1'b0;
        fall_cyc = cyc;
      end
    end
  end

  initial begin
    prev_req = 1'b0;
    rise_cyc = 0;
    n_rise   = 0;
    n_viol   = 0;
    forever begin
      @(negedge clk);
      if (req && !prev_req) begin
        rise_cyc = cyc;
        n_rise   = n_rise + 1;
        if (ack) n_viol = n_viol + 1;
      end
      if (!req && prev_req && !ack) n_viol = n_viol + 1;
      prev_req = req;
    end
  end
endmodule

module test_hs_seq_par;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;
  localparam int TMO        = 300;
  localparam int N_VEC      = 8;
  localparam int N_RAND     = 20;
  // nibbles: a1 rise dly, a1 fall dly, a2 rise dly, a2 fall dly
  localparam logic [15:0] VEC [N_VEC] = '{
    16'h0000, 16'h1111, 16'h5100, 16'h0051,
    16'h3030, 16'h0303, 16'h7000, 16'h0007
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_req = 1'b0;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 1'b0;

  logic [3:0] d1r, d1f, d2r, d2f;
  logic s_ack, s_r1, s_r2, s_k1, s_k2;
  logic p_ack, p_r1, p_r2, p_k1, p_k2;
  int s1_rc, s1_fc, s1_nr, s1_nv, s2_rc, s2_fc, s2_nr, s2_nv;
  int q1_rc, q1_fc, q1_nr, q1_nv, q2_rc, q2_fc, q2_nr, q2_nv;
  int s_ack_rc, p_ack_rc;
  logic s_ack_prev, p_ack_prev;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_seq_par #(.PAR_MODE(1'b0)) i_hs_seq_par (
    .clk_i(clk), .rst_ni(rst_n), .p_req_i(p_req), .p_ack_o(s_ack),
    .a1_req_o(s_r1), .a1_ack_i(s_k1), .a2_req_o(s_r2), .a2_ack_i(s_k2)
  );
  hs_seq_par #(.PAR_MODE(1'b1)) i_hs_seq_par_p (
    .clk_i(clk), .rst_ni(rst_n), .p_req_i(p_req), .p_ack_o(p_ack),
    .a1_req_o(p_r1), .a1_ack_i(p_k1), .a2_req_o(p_r2), .a2_ack_i(p_k2)
  );

  test_responder i_rs1 (.clk(clk), .rst_n(rst_n), .req(s_r1), .dly_rise(d1r), .dly_fall(d1f),
    .cyc(cyc), .ack(s_k1), .rise_cyc(s1_rc), .fall_cyc(s1_fc), .n_rise(s1_nr), .n_viol(s1_nv));
  test_responder i_rs2 (.clk(clk), .rst_n(rst_n), .req(s_r2), .dly_rise(d2r), .dly_fall(d2f),
    .cyc(cyc), .ack(s_k2), .rise_cyc(s2_rc), .fall_cyc(s2_fc), .n_rise(s2_nr), .n_viol(s2_nv));
  test_responder i_rp1 (.clk(clk), .rst_n(rst_n), .req(p_r1), .dly_rise(d1r), .dly_fall(d1f),
    .cyc(cyc), .ack(p_k1), .rise_cyc(q1_rc), .fall_cyc(q1_fc), .n_rise(q1_nr), .n_viol(q1_nv));
  test_responder i_rp2 (.clk(clk), .rst_n(rst_n), .req(p_r2), .dly_rise(d2r), .dly_fall(d2f),
    .cyc(cyc), .ack(p_k2), .rise_cyc(q2_rc), .fall_cyc(q2_fc), .n_rise(q2_nr), .n_viol(q2_nv));

  initial begin
    s_ack_prev = 1'b0; p_ack_prev = 1'b0; s_ack_rc = 0; p_ack_rc = 0;
    forever begin
      @(negedge clk);
      if (s_ack && !s_ack_prev) s_ack_rc = cyc;
      if (p_ack && !p_ack_prev) p_ack_rc = cyc;
      s_ack_prev = s_ack;
      p_ack_prev = p_ack;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_round(input logic [15:0] v);
    int t;
    int b_s1, b_s2, b_q1, b_q2;
    bit held;
    bit quiet;
    @(negedge clk);
    {d1r, d1f, d2r, d2f} = v;
    b_s1 = s1_nr; b_s2 = s2_nr; b_q1 = q1_nr; b_q2 = q2_nr;
    p_req = 1'b1;
    t = 0;
    while (!(s_ack && p_ack) && t < TMO) begin
      @(negedge clk);
      t++;
    end
    chk(t < TMO, "R8 parent ack timeout", t, TMO);
    // R3: second child starts after first child back at zero
    chk(s2_rc > s1_fc, "R3 seq a2 rise vs a1 ack fall", s2_rc, s1_fc + 1);
    // R4: both children launched in one cycle
    chk(q1_rc == q2_rc, "R4 par a1/a2 rise cycle", q2_rc, q1_rc);
    // R5: join after the later return-to-zero
    chk(s_ack_rc > s2_fc, "R5 seq p_ack vs a2 ack fall", s_ack_rc, s2_fc + 1);
    chk(p_ack_rc > imax(q1_fc, q2_fc), "R5 par p_ack vs last ack fall", p_ack_rc,
        imax(q1_fc, q2_fc) + 1);
    held = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!s_ack || !p_ack) held = 1'b0;
    end
    chk(held, "R6 p_ack held while p_req high", int'(held), 1);
    p_req = 1'b0;
    t = 0;
    while ((s_ack || p_ack) && t < TMO) begin
      @(negedge clk);
      t++;
    end
    chk(t < TMO, "R6 p_ack fall after p_req fall", t, TMO);
    quiet = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (s_r1 || s_r2 || p_r1 || p_r2) quiet = 1'b0;
    end
    chk(quiet, "R7 child req low while parent idle", int'(quiet), 1);
    chk((s1_nr - b_s1 == 1) && (s2_nr - b_s2 == 1), "R8 seq one handshake per child",
        (s1_nr - b_s1) * 10 + (s2_nr - b_s2), 11);
    chk((q1_nr - b_q1 == 1) && (q2_nr - b_q2 == 1), "R8 par one handshake per child",
        (q1_nr - b_q1) * 10 + (q2_nr - b_q2), 11);
    chk(s1_nv + s2_nv + q1_nv + q2_nv == 0, "R2 child four-phase order",
        s1_nv + s2_nv + q1_nv + q2_nv, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG_CYC, 0);
    finish_run();
  end

  initial begin
    {d1r, d1f, d2r, d2f} = 16'h0000;
    // R1: outputs low in reset even with a pending parent request
    p_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(!s_ack && !s_r1 && !s_r2, "R1 seq reset outputs", {29'd0, s_ack, s_r1, s_r2}, 0);
    chk(!p_ack && !p_r1 && !p_r2, "R1 par reset outputs", {29'd0, p_ack, p_r1, p_r2}, 0);
    p_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!s_r1 && !s_r2 && !p_r1 && !p_r2, "R7 idle after reset",
        {28'd0, s_r1, s_r2, p_r1, p_r2}, 0);

    for (int k = 0; k < N_VEC; k++) run_round(VEC[k]);

    // randomised responder delays
    for (int k = 0; k < N_RAND; k++)
      run_round({4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)),
                 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))});

    // R8: back-to-back rounds with zero delay
    run_round(16'h0000);
    run_round(16'h0000);

    finish_run();
  end
endmodule